// File: doc/BRIEF.md
# Double Bus Fault Halt Monitor

This block watches the error strobes a processor's bus controller reports and compares them with the exception sequencer's stacking phase. The first bus error or address error seen in normal operation starts an exception. The block raises a one-cycle exception request and opens a stacking window. If a second error arrives while that window is still open, the processor cannot save its state. The block then classifies the error as a double fault and locks into a halted state. It asserts `halt_o` and suppresses every new processor bus cycle until a synchronous reset.

A retry strobe is kept apart from errors. A retried cycle is reissued as often as the bus asks for it. A retry never counts toward a double fault, and it masks any error reported in the same cycle. External bus arbitration keeps working while the core is halted, so other masters can still take the bus.

Top module: `dbf_halt_monitor`

## Requirements
- R1: An error (`bus_err_i` or `addr_err_i` high, `retry_i` low) with the window closed and the block not halted drives `exc_req_o` high for exactly the next cycle and opens the stacking window.
- R2: An error while the window is open sets `halt_o` from the next cycle on, and no `exc_req_o` pulse is produced for it.
- R3: Once `halt_o` is high, only reset lowers it; no error, retry, stacking marker or request input clears it.
- R4: With `rst` high at a clock edge, `halt_o`, `exc_req_o`, `retry_rpt_o`, `arb_grant_o` and the stacking window are all cleared after that edge.
- R5: `stack_done_i` closes the window, so a later error is a fresh single exception (R1) and not a double fault.
- R6: When `retry_i` is high in the same cycle as an error, the error is ignored: no pulse, no window change, no halt.
- R7: `retry_rpt_o` is high in the cycle after each cycle with `retry_i` high while not halted, with no limit on consecutive retries.
- R8: `cyc_issue_o` equals `cyc_req_i` in the same cycle while not halted, and is low whenever `halt_o` is high.
- R9: `arb_grant_o` equals `arb_req_i` delayed by one cycle, whether or not the block is halted.
- R10: `stack_start_i` opens the window without an exception pulse, so an error that follows it halts the block.
- R11: An error in the same cycle as `stack_done_i` while the window is open still counts as a double fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_err_i | input | 1 | Bus error strobe |
| addr_err_i | input | 1 | Address error strobe |
| retry_i | input | 1 | Retry request for the current cycle |
| stack_start_i | input | 1 | Sequencer begins stacking a frame |
| stack_done_i | input | 1 | Sequencer finished stacking |
| cyc_req_i | input | 1 | Processor requests a new bus cycle |
| arb_req_i | input | 1 | External master requests the bus |
| halt_o | output | 1 | Halted after a double fault |
| exc_req_o | output | 1 | One-cycle exception request |
| retry_rpt_o | output | 1 | Reissue the retried cycle |
| cyc_issue_o | output | 1 | Processor bus cycle allowed to start |
| arb_grant_o | output | 1 | Bus granted to the external master |

## Verification
The bench aims at the window edges. It sends an error in the same cycle as `stack_done_i`, an error one cycle after it, and an error after a bare `stack_start_i`. A design that closed the window too early would miss the double fault, and one that kept it open too long would halt on a legitimate handler error. It also pairs errors with retries, including long retry runs. A design that gave errors precedence would pulse or halt spuriously, and one that capped retries would drop `retry_rpt_o`. Once halted, it hammers every input and requests arbitration. A non-sticky halt would clear, a leaky gate would issue cycles, and a halt wired to arbitration would starve the grant.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef struct packed {
        logic window;
        logic halted;
        logic exc;
        logic rpt;
    } fault_st_t;

    localparam fault_st_t FAULT_RST = '{window: 1'b0, halted: 1'b0, exc: 1'b0, rpt: 1'b0};
endpackage

// File: rtl/dbf_err_qual.sv
module dbf_err_qual (
    input  logic bus_err_i,
    input  logic addr_err_i,
    input  logic retry_i,
    output logic err_o
);
    // a retry outranks any error reported in the same cycle
    always_comb begin
        err_o = 1'b0;
        if (!retry_i) begin
            err_o = bus_err_i | addr_err_i;
        end
    end
endmodule

// File: rtl/dbf_fault_core.sv
module dbf_fault_core
    import dbf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_i,
    input  logic retry_i,
    input  logic stack_start_i,
    input  logic stack_done_i,
    output logic halted_o,
    output logic exc_o,
    output logic rpt_o
);
    fault_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        st_d.rpt = retry_i & ~st_q.halted;
        if (st_q.halted) begin
            st_d.window = 1'b0;
        end else if (err_i && st_q.window) begin
            st_d.halted = 1'b1;
            st_d.window = 1'b0;
        end else begin
            st_d.exc = err_i;
            if (err_i || stack_start_i) begin
                st_d.window = 1'b1;
            end else if (stack_done_i) begin
                st_d.window = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= FAULT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted_o = st_q.halted;
    assign exc_o    = st_q.exc;
    assign rpt_o    = st_q.rpt;

    p_exc_single_r1: assert property (@(posedge clk) disable iff (rst)
        exc_o |=> !exc_o);
    p_double_halts_r2: assert property (@(posedge clk) disable iff (rst)
        (err_i && st_q.window && !halted_o) |=> (halted_o && !exc_o));
    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> halted_o);
    p_retry_masks_r6: assert property (@(posedge clk) disable iff (rst)
        (retry_i && !halted_o) |=> !exc_o);
    p_rpt_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (retry_i && !halted_o) |=> rpt_o);
    p_start_opens_r10: assert property (@(posedge clk) disable iff (rst)
        (stack_start_i && !err_i && !halted_o) |=> !exc_o);
endmodule

// File: rtl/dbf_bus_gate.sv
module dbf_bus_gate (
    input  logic clk,
    input  logic rst,
    input  logic halted_i,
    input  logic cyc_req_i,
    input  logic arb_req_i,
    output logic cyc_issue_o,
    output logic arb_grant_o
);
    logic grant_q, grant_d;

    always_comb begin
        grant_d     = arb_req_i;
        cyc_issue_o = cyc_req_i & ~halted_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign arb_grant_o = grant_q;

    p_no_issue_halted_r8: assert property (@(posedge clk) disable iff (rst)
        halted_i |-> !cyc_issue_o);
    p_grant_alive_r9: assert property (@(posedge clk) disable iff (rst)
        arb_req_i |=> arb_grant_o);
endmodule

// File: rtl/dbf_halt_monitor.sv
module dbf_halt_monitor (
    input  logic clk,
    input  logic rst,
    input  logic bus_err_i,
    input  logic addr_err_i,
    input  logic retry_i,
    input  logic stack_start_i,
    input  logic stack_done_i,
    input  logic cyc_req_i,
    input  logic arb_req_i,
    output logic halt_o,
    output logic exc_req_o,
    output logic retry_rpt_o,
    output logic cyc_issue_o,
    output logic arb_grant_o
);
    logic err_ok;

    dbf_err_qual u_qual (
        .bus_err_i  (bus_err_i),
        .addr_err_i (addr_err_i),
        .retry_i    (retry_i),
        .err_o      (err_ok)
    );

    dbf_fault_core u_core (
        .clk           (clk),
        .rst           (rst),
        .err_i         (err_ok),
        .retry_i       (retry_i),
        .stack_start_i (stack_start_i),
        .stack_done_i  (stack_done_i),
        .halted_o      (halt_o),
        .exc_o         (exc_req_o),
        .rpt_o         (retry_rpt_o)
    );

    dbf_bus_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .halted_i    (halt_o),
        .cyc_req_i   (cyc_req_i),
        .arb_req_i   (arb_req_i),
        .cyc_issue_o (cyc_issue_o),
        .arb_grant_o (arb_grant_o)
    );

    p_reset_clears_r4: assert property (@(posedge clk)
        rst |=> (!halt_o && !exc_req_o && !retry_rpt_o && !arb_grant_o));
endmodule

// File: tb/dbf_halt_monitor_tb.sv
module dbf_halt_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_err_i = 0, addr_err_i = 0, retry_i = 0;
    logic stack_start_i = 0, stack_done_i = 0, cyc_req_i = 0, arb_req_i = 0;
    logic halt_o, exc_req_o, retry_rpt_o, cyc_issue_o, arb_grant_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state, derived from the requirements
    logic m_win = 0, m_halt = 0, m_exc = 0, m_rpt = 0, m_gnt = 0;

    always #2 clk = ~clk;

    dbf_halt_monitor u_dut (
        .clk(clk), .rst(rst),
        .bus_err_i(bus_err_i), .addr_err_i(addr_err_i), .retry_i(retry_i),
        .stack_start_i(stack_start_i), .stack_done_i(stack_done_i),
        .cyc_req_i(cyc_req_i), .arb_req_i(arb_req_i),
        .halt_o(halt_o), .exc_req_o(exc_req_o), .retry_rpt_o(retry_rpt_o),
        .cyc_issue_o(cyc_issue_o), .arb_grant_o(arb_grant_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_issue(input logic req, input logic hlt);
        return req & ~hlt;
    endfunction

    // one cycle: check registered outputs, drive, check comb output, advance model
    task automatic cyc(input logic r, input logic be, input logic ae, input logic rt,
                       input logic ss, input logic sd, input logic cr, input logic ar,
                       input string tag);
        logic err;
        @(negedge clk);
        check(halt_o, m_halt, {tag, " R2/R3 halt"});
        check(exc_req_o, m_exc, {tag, " R1 exc"});
        check(retry_rpt_o, m_rpt, {tag, " R7 rpt"});
        check(arb_grant_o, m_gnt, {tag, " R9 grant"});
        rst = r; bus_err_i = be; addr_err_i = ae; retry_i = rt;
        stack_start_i = ss; stack_done_i = sd; cyc_req_i = cr; arb_req_i = ar;
        #1;
        check(cyc_issue_o, model_issue(cr, m_halt), {tag, " R8 issue"});
        err = (be | ae) & ~rt;
        if (r) begin
            m_win = 0; m_halt = 0; m_exc = 0; m_rpt = 0; m_gnt = 0;
        end else begin
            m_rpt = rt & ~m_halt;
            m_gnt = ar;
            if (m_halt) begin
                m_exc = 0; m_win = 0;
            end else if (err & m_win) begin
                m_halt = 1; m_exc = 0; m_win = 0;
            end else begin
                m_exc = err;
                m_win = (m_win & ~sd) | err | ss;
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,1,0,tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R4: reset state
        cyc(1,0,0,0,0,0,0,0,"R4 rst");
        cyc(1,0,0,0,0,0,0,0,"R4 rst");
        idle(2, "R4 after reset");
        // R1 then R5: single error, stack done, handler error is fresh
        cyc(0,1,0,0,0,0,1,0,"R1 first err");
        idle(2, "R1 window");
        cyc(0,0,0,0,0,1,1,0,"R5 done");
        cyc(0,0,1,0,0,0,1,0,"R5 handler err");
        idle(1, "R5 pulse");
        // R11: error with done while open -> halt
        cyc(0,1,0,0,0,1,1,0,"R11 err+done");
        idle(1, "R11 halted");
        check(halt_o, 1'b1, "R11 halt set");
        // R3: hammer inputs while halted; R9 grant alive, R8 no issue
        for (int i = 0; i < 20; i++)
            cyc(0,$urandom%2,$urandom%2,$urandom%2,$urandom%2,$urandom%2,1,$urandom%2,"R3 halted");
        check(halt_o, 1'b1, "R3 still halted");
        cyc(0,0,0,0,0,0,1,1,"R9 arb while halted");
        idle(1, "R9");
        // R4: reset leaves halt
        cyc(1,0,0,0,0,0,0,0,"R4 rst2");
        idle(1, "R4 cleared");
        check(halt_o, 1'b0, "R4 halt cleared");
        // R6: error with retry ignored, then long retry run (R7)
        cyc(0,1,1,1,0,0,1,0,"R6 err+retry");
        idle(1, "R6 none");
        check(exc_req_o, 1'b0, "R6 no pulse");
        for (int i = 0; i < 30; i++) cyc(0,1,0,1,0,0,1,0,"R7 retry run");
        idle(1, "R7 end");
        // R6: window not opened by masked error -> next error is single
        cyc(0,0,1,0,0,0,1,0,"R6 single after retry");
        idle(1, "R6 pulse");
        cyc(0,0,0,0,0,1,1,0,"R5 close");
        // R10: stack_start opens window, then error halts
        cyc(0,0,0,0,1,0,1,0,"R10 start");
        cyc(0,1,0,0,0,0,1,0,"R10 err");
        idle(1, "R10 halted");
        check(halt_o, 1'b1, "R10 halt");
        cyc(1,0,0,0,0,0,0,0,"R4 rst3");
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic r;
            r = ($urandom % 200) == 0;
            cyc(r, ($urandom%8)==0, ($urandom%12)==0, ($urandom%5)==0,
                ($urandom%10)==0, ($urandom%4)==0, $urandom%2, $urandom%2, "RND");
        end
        idle(1, "final");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule